// File: doc/BRIEF.md
# Charge and Energy Accumulator

This block integrates measured samples over time. Each channel carries a signed current sample and a signed power sample. From them it keeps three running totals: charge (the sum of current samples), energy (the sum of power samples) and elapsed time (the number of samples counted). All totals advance on a single sample-valid strobe.

Each total has its own two-bit mode. A total can be frozen, or it can follow every strobe. It can also follow a strobe only when that channel's current is on one side of a symmetric deadband around zero. This lets a host separate charging from discharging and ignore noise near zero.

Each total is compared with a guard level set at nine tenths of its largest positive value. When a total first moves to or past the guard in either direction, a sticky warning bit is raised, and accumulation carries on unchanged. The host can zero any single total, together with its warning bit, through a per-total clear input.

Top module: `charge_energy_accum`

## Requirements
- R1: After reset every total reads 0 and every warning bit reads 0.
- R2: Mode code 00 freezes a total: a strobe leaves it unchanged.
- R3: Mode code 01 makes a total follow every strobe. Charge adds the signed current, energy adds the signed power, and time adds 1. The new value appears on the clock edge that samples the strobe.
- R4: Mode code 10 adds only when the channel's current, taken as signed, is strictly greater than the unsigned deadband value.
- R5: Mode code 11 adds only when the channel's current is strictly less than the negated deadband value.
- R6: A cycle with the strobe low changes no total, whatever the sample and mode inputs hold.
- R7: The guard level is floor((2^(ACC_W-1)-1)*9/10). A total's warning bit is set by the update that leaves the total at or above the guard level, or at or below the negated guard level.
- R8: Totals neither stop nor saturate at the guard level. They keep adding and wrap modulo 2^ACC_W.
- R9: A warning bit, once set, stays set until that total is cleared, even if the total later falls back below the guard level.
- R10: A clear bit zeroes its own total and warning bit on the next edge. The clear takes priority over a strobe in the same cycle, and totals whose clear bit is low update normally. Total index k = 3*channel + q, where q is 0 for charge, 1 for energy and 2 for time. Mode bits for total k sit at [2k+1:2k].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_valid | input | 1 | Sample strobe, one update per high cycle |
| cur_i | input | NUM_CH*SMP_W | Signed current sample per channel |
| pwr_i | input | NUM_CH*SMP_W | Signed power sample per channel |
| mode_i | input | NUM_CH*6 | Two-bit mode per total |
| deadband_i | input | SMP_W-1 | Unsigned deadband magnitude |
| clr_i | input | NUM_CH*3 | Per-total clear request |
| acc_o | output | NUM_CH*3*ACC_W | Total values, signed |
| guard_o | output | NUM_CH*3 | Sticky guard warning bits |

## Verification
A wrong internal total shows up at acc_o on the edge after the faulty strobe. From then on it stays wrong, because every later update builds on it. A wrong gate decision therefore shows up as a value that drifts from the arithmetic sum the bench keeps for every mode and deadband. A wrong guard level or a lost sticky bit shows at guard_o on the edge where the total crosses, or on the first edge after it falls back below the guard. The bench compares every total and every warning bit after every cycle, so any divergence is caught one clock after it arises.

// File: rtl/acc_pkg.sv
package acc_pkg;
    typedef enum logic [1:0] {
        MODE_OFF    = 2'b00,
        MODE_ALWAYS = 2'b01,
        MODE_POS    = 2'b10,
        MODE_NEG    = 2'b11
    } acc_mode_e;

    localparam int TOTALS_PER_CH = 3;
    localparam int Q_CHARGE = 0;
    localparam int Q_ENERGY = 1;
    localparam int Q_TIME   = 2;
endpackage

// File: rtl/acc_gate.sv
module acc_gate #(
    parameter int SMP_W = 24
) (
    input  logic [1:0]       mode,
    input  logic [SMP_W-1:0] cur,
    input  logic [SMP_W-2:0] deadband,
    output logic             go
);
    import acc_pkg::*;

    logic signed [SMP_W:0] cur_x;
    logic signed [SMP_W:0] db_x;
    logic                  above;
    logic                  below;

    always_comb begin
        cur_x = {cur[SMP_W-1], cur};
        db_x  = {2'b00, deadband};
        above = cur_x > db_x;
        below = cur_x < -db_x;
        unique case (acc_mode_e'(mode))
            MODE_OFF:    go = 1'b0;
            MODE_ALWAYS: go = 1'b1;
            MODE_POS:    go = above;
            MODE_NEG:    go = below;
            default:     go = 1'b0;
        endcase
    end

    always_comb begin
        if (!$isunknown({mode, cur, deadband})) begin
            assert_pos_sign_R4: assert (!(go && mode == 2'b10 && cur[SMP_W-1]));
            assert_neg_sign_R5: assert (!(go && mode == 2'b11 && !cur[SMP_W-1]));
        end
    end
endmodule

// File: rtl/acc_cell.sv
module acc_cell #(
    parameter int ACC_W = 48,
    parameter int SMP_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             clr,
    input  logic [SMP_W-1:0] inc,
    output logic [ACC_W-1:0] acc_q,
    output logic             guard_q
);
    localparam int EXT_W = ACC_W + 4;
    localparam logic [EXT_W-1:0] MAX_POS = EXT_W'({1'b0, {(ACC_W-1){1'b1}}});
    localparam logic [EXT_W-1:0] GUARD_X = (MAX_POS * EXT_W'(9)) / EXT_W'(10);
    localparam logic signed [ACC_W-1:0] GUARD = GUARD_X[ACC_W-1:0];

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             flag;
    } cell_t;

    cell_t            st_d, st_q;
    logic [ACC_W-1:0] inc_x;
    logic [ACC_W-1:0] sum;
    logic             crossed;

    always_comb begin
        inc_x   = {{(ACC_W-SMP_W){inc[SMP_W-1]}}, inc};
        sum     = st_q.acc + inc_x;
        crossed = ($signed(sum) >= GUARD) || ($signed(sum) <= -GUARD);
        st_d    = st_q;
        if (clr) begin
            st_d.acc  = '0;
            st_d.flag = 1'b0;
        end else if (en) begin
            st_d.acc  = sum;
            st_d.flag = st_q.flag | crossed;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_q   = st_q.acc;
    assign guard_q = st_q.flag;

    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        guard_q && !clr |=> guard_q);
    assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc_q == '0) && !guard_q);
    assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !en && !clr |=> $stable(acc_q) && $stable(guard_q));
    assert_guard_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($signed(acc_q) >= GUARD || $signed(acc_q) <= -GUARD) |-> guard_q);
endmodule

// File: rtl/charge_energy_accum.sv
module charge_energy_accum #(
    parameter int NUM_CH = 2,
    parameter int SMP_W  = 24,
    parameter int ACC_W  = 48
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          smp_valid,
    input  logic [NUM_CH*SMP_W-1:0]       cur_i,
    input  logic [NUM_CH*SMP_W-1:0]       pwr_i,
    input  logic [NUM_CH*6-1:0]           mode_i,
    input  logic [SMP_W-2:0]              deadband_i,
    input  logic [NUM_CH*3-1:0]           clr_i,
    output logic [NUM_CH*3*ACC_W-1:0]     acc_o,
    output logic [NUM_CH*3-1:0]           guard_o
);
    import acc_pkg::*;

    localparam int N_TOT = NUM_CH * TOTALS_PER_CH;

    logic [N_TOT-1:0] go;
    logic [N_TOT-1:0] en;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        for (genvar q = 0; q < TOTALS_PER_CH; q++) begin : g_q
            localparam int K = ch * TOTALS_PER_CH + q;
            logic [SMP_W-1:0] inc;

            if (q == Q_CHARGE) begin : g_chg
                assign inc = cur_i[ch*SMP_W +: SMP_W];
            end else if (q == Q_ENERGY) begin : g_nrg
                assign inc = pwr_i[ch*SMP_W +: SMP_W];
            end else begin : g_tim
                assign inc = SMP_W'(1);
            end

            acc_gate #(.SMP_W(SMP_W)) u_gate (
                .mode     (mode_i[2*K +: 2]),
                .cur      (cur_i[ch*SMP_W +: SMP_W]),
                .deadband (deadband_i),
                .go       (go[K])
            );

            assign en[K] = smp_valid & go[K];

            acc_cell #(.ACC_W(ACC_W), .SMP_W(SMP_W)) u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .en      (en[K]),
                .clr     (clr_i[K]),
                .inc     (inc),
                .acc_q   (acc_o[K*ACC_W +: ACC_W]),
                .guard_q (guard_o[K])
            );
        end
    end

    assert_no_strobe_no_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |-> en == '0);
endmodule

// File: tb/tb_charge_energy_accum.sv
module tb_charge_energy_accum;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;
    localparam int SW  = 8;
    localparam int AW  = 12;
    localparam int NT  = NCH * 3;
    localparam int GUARD = ((2 ** (AW - 1)) - 1) * 9 / 10;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 smp_valid = 1'b0;
    logic [NCH*SW-1:0]    cur_i = '0;
    logic [NCH*SW-1:0]    pwr_i = '0;
    logic [NCH*6-1:0]     mode_i = '0;
    logic [SW-2:0]        deadband_i = '0;
    logic [NT-1:0]        clr_i = '0;
    logic [NT*AW-1:0]     acc_o;
    logic [NT-1:0]        guard_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    logic signed [AW-1:0] exp_acc [NT];
    logic                 exp_flg [NT];

    always #(CLK_PERIOD/2) clk = ~clk;

    charge_energy_accum #(.NUM_CH(NCH), .SMP_W(SW), .ACC_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .cur_i(cur_i),
        .pwr_i(pwr_i), .mode_i(mode_i), .deadband_i(deadband_i),
        .clr_i(clr_i), .acc_o(acc_o), .guard_o(guard_o)
    );

    function automatic logic gate_f(logic [1:0] m, logic signed [SW-1:0] c, logic [SW-2:0] d);
        int ci = int'(c);
        int di = int'(d);
        case (m)
            2'b00:   return 1'b0;
            2'b01:   return 1'b1;
            2'b10:   return ci > di;
            default: return ci < -di;
        endcase
    endfunction

    task automatic check_all(input string tag);
        for (int k = 0; k < NT; k++) begin
            logic signed [AW-1:0] a;
            a = acc_o[k*AW +: AW];
            n_checks++;
            if (a !== exp_acc[k]) begin
                n_fail++;
                $display("FAIL %s total %0d value actual=%0d expected=%0d", tag, k, a, exp_acc[k]);
            end
            n_checks++;
            if (guard_o[k] !== exp_flg[k]) begin
                n_fail++;
                $display("FAIL %s total %0d guard actual=%b expected=%b", tag, k, guard_o[k], exp_flg[k]);
            end
        end
    endtask

    task automatic step(input logic v, input int c0, input int c1, input int p0, input int p1,
                        input logic [NT-1:0] clr, input string tag);
        logic signed [SW-1:0] cs [NCH];
        logic signed [SW-1:0] ps [NCH];
        @(negedge clk);
        cs[0] = SW'(c0); cs[1] = SW'(c1);
        ps[0] = SW'(p0); ps[1] = SW'(p1);
        smp_valid = v;
        cur_i = {cs[1], cs[0]};
        pwr_i = {ps[1], ps[0]};
        clr_i = clr;
        for (int k = 0; k < NT; k++) begin
            int ch = k / 3;
            int q = k % 3;
            int inc = (q == 0) ? int'(cs[ch]) : (q == 1) ? int'(ps[ch]) : 1;
            if (clr[k]) begin
                exp_acc[k] = '0;
                exp_flg[k] = 1'b0;
            end else if (v && gate_f(mode_i[2*k +: 2], cs[ch], deadband_i)) begin
                int s = int'(exp_acc[k]) + inc;
                logic signed [AW-1:0] w;
                w = s[AW-1:0];
                exp_acc[k] = w;
                if (int'(w) >= GUARD || int'(w) <= -GUARD) exp_flg[k] = 1'b1;
            end
        end
        @(posedge clk);
        #1;
        check_all(tag);
        @(negedge clk);
        clr_i = '0;
        smp_valid = 1'b0;
    endtask

    task automatic set_mode_all(input logic [1:0] m);
        for (int k = 0; k < NT; k++) mode_i[2*k +: 2] = m;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        string tags [4];
        tags[0] = "R2"; tags[1] = "R3"; tags[2] = "R4"; tags[3] = "R5";
        for (int k = 0; k < NT; k++) begin
            exp_acc[k] = '0;
            exp_flg[k] = 1'b0;
        end
        repeat (3) @(posedge clk);
        // R1: reset state checked while held and after release
        #1;
        check_all("R1");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check_all("R1");

        // R2..R5: mode and deadband sweep
        for (int m = 0; m < 4; m++) begin
            set_mode_all(2'(m));
            step(1'b0, 0, 0, 0, 0, '1, "R10");
            for (int d = 0; d < 3; d++) begin
                deadband_i = (d == 0) ? 7'd0 : (d == 1) ? 7'd7 : 7'd127;
                for (int c = -12; c <= 12; c += 3) begin
                    step(1'b1, c, -c, c * 3, 5 - c, '0, tags[m]);
                end
                // exact deadband boundary: equal value must not add
                step(1'b1, int'(deadband_i), -int'(deadband_i), 9, 9, '0, tags[m]);
            end
        end

        // R6: strobe low with busy inputs
        set_mode_all(2'b01);
        for (int i = 0; i < 8; i++) step(1'b0, 50 + i, -40 - i, 100, -100, '0, "R6");

        // R7/R8/R9: drive charge0 up and energy0 down past the guard and through the wrap
        step(1'b0, 0, 0, 0, 0, '1, "R10");
        deadband_i = '0;
        for (int i = 0; i < 45; i++) step(1'b1, 100, 0, -100, 0, '0, (i < 19) ? "R7" : "R8");
        n_checks++;
        if (guard_o[0] !== 1'b1 || guard_o[1] !== 1'b1) begin
            n_fail++;
            $display("FAIL R9 sticky guard actual=%b%b expected=11", guard_o[1], guard_o[0]);
        end
        n_checks++;
        if ($signed(acc_o[0 +: AW]) >= GUARD) begin
            n_fail++;
            $display("FAIL R8 wrap actual=%0d expected below %0d", $signed(acc_o[0 +: AW]), GUARD);
        end

        // R10: clear with simultaneous strobe, single totals
        step(1'b1, 20, 30, 40, 50, 6'b000001, "R10");
        step(1'b1, 20, 30, 40, 50, 6'b010010, "R10");
        step(1'b1, -5, 6, -7, 8, 6'b100100, "R10");
        mode_i[2*3 +: 2] = 2'b10;
        mode_i[2*4 +: 2] = 2'b11;
        deadband_i = 7'd3;
        for (int c = -6; c <= 6; c++) step(1'b1, 1, c, 2, c, '0, "R4");

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule